// File: doc/BRIEF.md
# Oversampled Bit Clock Recovery Unit

This block takes a demodulated, already-sliced serial stream and recovers from it a bit clock and retimed data. A divider inside the block turns the system clock into an oversampling tick that runs at 29 times the programmed bit rate. A phase counter steps once per tick through a 29-position bit window. Every transition seen on the synchronised input is measured against the expected bit boundary, and the counter is pulled toward it. The data is taken near the middle of the window and announced with a one-cycle strobe.

The tracking loop has three modes. Fast mode makes large corrections and settles on a short alternating preamble. Slow mode moves one tick per edge, so it rejects noise but needs a longer preamble. Automatic mode starts fast and drops to slow once lock is reached. A lock flag reports when enough consecutive edges have landed close to the expected boundary, and it clears when edges keep falling outside that window.

Top module: `cru_top`

## Requirements
- R1: While reset is asserted, `locked`, `bit_strobe` and `rx_data` are 0. Deasserting `enable` clears `locked`, returns the phase counter to 0 and stops all strobes until `enable` is set again.
- R2: The oversampling tick occurs once every (rate_div+1)·(rate_x8 ? 8 : 1) system clocks. On a clean, locked stream, consecutive strobes are therefore exactly 29·(rate_div+1)·(rate_x8 ? 8 : 1) clocks apart.
- R3: On the tick where the phase counter reads 14, the synchronised input is captured into `rx_data` and `bit_strobe` goes high for one cycle. `rx_data` changes only together with a strobe, so the recovered bits equal the transmitted bits.
- R4: At an edge seen at phase p, the error is e = p for p ≤ 14 and e = p − 29 otherwise. Fast mode subtracts ceil(|e|/2) with the sign of e from the next phase, so it locks within 10 bits of a 1010 preamble even when the first edge is half a bit off.
- R5: Slow mode corrects by exactly one tick toward the boundary per edge, so with a half-bit initial offset it is still unlocked after 8 preamble bits.
- R6: `locked` rises after `lock_edges` consecutive edges with |e| ≤ 2. An edge outside this window restarts the count.
- R7: Slow mode locks within 24 bits of a 1010 preamble from any starting phase when `lock_edges` = 4.
- R8: While locked, 3 consecutive edges with |e| > 2 clear `locked`. An in-window edge restarts this count.
- R9: With `auto_mode` = 1, the loop is fast (`fast_track` = 1) until lock and slow after lock, and `fast_sel` has no effect.
- R10: Losing lock in automatic mode, or clearing `auto_mode`, returns the loop to fast mode. In the second case this holds only if `fast_sel` = 1.
- R11: With `auto_mode` = 0, `fast_sel` = 1 selects fast mode and `fast_sel` = 0 selects slow mode.
- R12: With each bit boundary moved randomly by up to ±1 clock (`rate_div` = 0, `rate_x8` = 0), lock is held and every recovered bit is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the recovery loop; low clears lock and phase |
| din | input | 1 | Sliced serial data, asynchronous to clk |
| rate_div | input | 7 | Tick divider value; the divide ratio is this value plus 1 |
| rate_x8 | input | 1 | Multiplies the tick divide ratio by 8 |
| auto_mode | input | 1 | Automatic fast-to-slow loop selection |
| fast_sel | input | 1 | Manual loop select: 1 fast, 0 slow |
| lock_edges | input | 4 | Consecutive in-window edges needed to declare lock |
| rx_data | output | 1 | Recovered data bit |
| bit_strobe | output | 1 | One-cycle pulse with each recovered bit |
| locked | output | 1 | Lock indicator |
| fast_track | output | 1 | High while the loop applies fast corrections |

## Verification
The bench starts preambles half a bit away from the counter's phase. If the fast step were too small, lock would come too late. If the slow step were too large, slow mode would lock as early as fast mode. The bench also inserts a half-bit slip after lock. A miss counter that never resets, or a lock flag that sticks, shows up there, and so does an automatic mode that stays slow after losing lock. Strobe spacing is measured at two divider settings, which exposes an off-by-one in the tick divider or in the window length. Boundaries with ±1 clock of jitter and random data catch a sample point that sits off centre.

// File: rtl/cru_pkg.sv
package cru_pkg;

    // Signed distance of a detected edge from the expected boundary (phase 0).
    function automatic int phase_err(input int ph, input int osr);
        return (ph <= osr / 2) ? ph : ph - osr;
    endfunction

    // Correction applied to the phase counter for a given error.
    function automatic int phase_step(input int err, input logic fast);
        int mag;
        int s;
        mag = (err < 0) ? -err : err;
        if (fast) s = (mag + 1) / 2;
        else      s = (mag != 0) ? 1 : 0;
        return (err < 0) ? -s : s;
    endfunction

endpackage

// File: rtl/cru_sync.sv
module cru_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/cru_tick_gen.sv
module cru_tick_gen #(
    parameter int RATE_W    = 7,
    parameter int PRE_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate_div,
    input  logic              rate_x8,
    output logic              tick
);
    localparam int CNT_W = RATE_W + PRE_SHIFT + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tg_t;

    tg_t tg_d, tg_q;
    logic [CNT_W-1:0] base, limit_m1;

    always_comb begin
        base     = CNT_W'(rate_div) + CNT_W'(1);
        limit_m1 = (rate_x8 ? (base << PRE_SHIFT) : base) - CNT_W'(1);
        tg_d      = tg_q;
        tg_d.tick = 1'b0;
        if (!enable) begin
            tg_d.cnt = '0;
        end else if (tg_q.cnt >= limit_m1) begin
            tg_d.cnt  = '0;
            tg_d.tick = 1'b1;
        end else begin
            tg_d.cnt = tg_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end

    assign tick = tg_q.tick;

    // R2: back-to-back ticks only when the divide ratio is one
    p_tick_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tg_q.tick && $past(tg_q.tick) |-> $past(limit_m1) == '0);
endmodule

// File: rtl/cru_phase_track.sv
module cru_phase_track
    import cru_pkg::*;
#(
    parameter int OSR        = 29,
    parameter int WIN        = 2,
    parameter int MISS_LIMIT = 3,
    parameter int LOCK_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              din_s,
    input  logic              auto_mode,
    input  logic              fast_sel,
    input  logic [LOCK_W-1:0] lock_edges,
    output logic              rx_data,
    output logic              bit_strobe,
    output logic              locked,
    output logic              fast_track
);
    localparam int PH_W      = $clog2(OSR);
    localparam int SAMPLE_PT = OSR / 2;
    localparam int MISS_W    = $clog2(MISS_LIMIT + 1);

    typedef struct packed {
        logic [PH_W-1:0]   ph;
        logic              prev;
        logic              data;
        logic              strobe;
        logic              locked;
        logic [LOCK_W-1:0] hits;
        logic [MISS_W-1:0] misses;
    } trk_t;

    trk_t st_d, st_q;
    logic trans, in_win, fast;
    int   err, corr, step;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        fast   = auto_mode ? !st_q.locked : fast_sel;
        trans  = 1'b0;
        in_win = 1'b0;
        err    = 0;
        corr   = 0;
        step   = 0;
        if (!enable) begin
            st_d.ph     = '0;
            st_d.prev   = din_s;
            st_d.locked = 1'b0;
            st_d.hits   = '0;
            st_d.misses = '0;
        end else if (tick) begin
            st_d.prev = din_s;
            trans     = (din_s != st_q.prev);
            if (int'(st_q.ph) == SAMPLE_PT) begin
                st_d.data   = din_s;
                st_d.strobe = 1'b1;
            end
            if (trans) begin
                err    = phase_err(int'(st_q.ph), OSR);
                in_win = (err <= WIN) && (err >= -WIN);
                corr   = phase_step(err, fast);
                step   = int'(st_q.ph) + 1 - corr;
                if (step < 0)         step = step + OSR;
                else if (step >= OSR) step = step - OSR;
                st_d.ph = PH_W'(step);
                if (in_win) begin
                    st_d.misses = '0;
                    if (!st_q.locked) begin
                        if (int'(st_q.hits) + 1 >= int'(lock_edges)) begin
                            st_d.locked = 1'b1;
                            st_d.hits   = '0;
                        end else begin
                            st_d.hits = st_q.hits + LOCK_W'(1);
                        end
                    end
                end else begin
                    st_d.hits = '0;
                    if (st_q.locked) begin
                        if (int'(st_q.misses) + 1 >= MISS_LIMIT) begin
                            st_d.locked = 1'b0;
                            st_d.misses = '0;
                        end else begin
                            st_d.misses = st_q.misses + MISS_W'(1);
                        end
                    end
                end
            end else begin
                st_d.ph = (int'(st_q.ph) == OSR - 1) ? '0 : st_q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data    = st_q.data;
    assign bit_strobe = st_q.strobe;
    assign locked     = st_q.locked;
    assign fast_track = fast;

    // R4: the phase counter never leaves the bit window
    p_ph_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.ph) < OSR);

    // R3: a strobe always follows an oversampling tick
    p_strobe_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |-> $past(tick));

    // R6: lock is only gained on an in-window edge
    p_lock_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(enable && tick && trans && in_win));

    // R8: lock is only lost on disable or on an out-of-window edge
    p_unlock_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.locked) |-> $past(!enable || (tick && trans && !in_win)));
endmodule

// File: rtl/cru_top.sv
module cru_top #(
    parameter int OSR         = 29,
    parameter int RATE_W      = 7,
    parameter int PRE_SHIFT   = 3,
    parameter int LOCK_W      = 4,
    parameter int WIN         = 2,
    parameter int MISS_LIMIT  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              din,
    input  logic [RATE_W-1:0] rate_div,
    input  logic              rate_x8,
    input  logic              auto_mode,
    input  logic              fast_sel,
    input  logic [LOCK_W-1:0] lock_edges,
    output logic              rx_data,
    output logic              bit_strobe,
    output logic              locked,
    output logic              fast_track
);
    logic din_s;
    logic tick;

    cru_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .dout (din_s)
    );

    cru_tick_gen #(.RATE_W(RATE_W), .PRE_SHIFT(PRE_SHIFT)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .rate_div(rate_div),
        .rate_x8 (rate_x8),
        .tick    (tick)
    );

    cru_phase_track #(
        .OSR       (OSR),
        .WIN       (WIN),
        .MISS_LIMIT(MISS_LIMIT),
        .LOCK_W    (LOCK_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .din_s     (din_s),
        .auto_mode (auto_mode),
        .fast_sel  (fast_sel),
        .lock_edges(lock_edges),
        .rx_data   (rx_data),
        .bit_strobe(bit_strobe),
        .locked    (locked),
        .fast_track(fast_track)
    );

    // R3: recovered data only changes together with a strobe
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_strobe |-> $stable(rx_data));
endmodule

// File: tb/cru_top_bench.sv
module cru_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       din = 1'b0;
    logic [6:0] rate_div = 7'd0;
    logic       rate_x8 = 1'b0;
    logic       auto_mode = 1'b1;
    logic       fast_sel = 1'b0;
    logic [3:0] lock_edges = 4'd4;
    logic       rx_data, bit_strobe, locked, fast_track;

    cru_top u_cru_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .din(din),
        .rate_div(rate_div), .rate_x8(rate_x8), .auto_mode(auto_mode),
        .fast_sel(fast_sel), .lock_edges(lock_edges),
        .rx_data(rx_data), .bit_strobe(bit_strobe), .locked(locked),
        .fast_track(fast_track)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;

    int bstart [0:4095];
    bit bval   [0:4095];
    int nb = 0;

    bit    data_en = 0;
    string data_req = "R3";
    bit    gap_en = 0;
    int    exp_gap = 29;
    int    last_strobe = -1;
    bit    prev_strobe = 0;
    int    strobe_cnt = 0;
    bit    mon_en = 0;
    bit    saw_unlock = 0;
    bit    saw_fast = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period(input int rd, input bit x8);
        return 29 * (rd + 1) * (x8 ? 8 : 1);
    endfunction

    // Expected bit: the one being driven a few clocks before the strobe
    function automatic bit expected_bit(input int at);
        int lo;
        lo = (nb > 8) ? nb - 8 : 0;
        for (int i = nb - 1; i >= lo; i--) begin
            if (bstart[i] <= at) return bval[i];
        end
        return bval[lo];
    endfunction

    always @(negedge clk) begin
        if (bit_strobe) begin
            strobe_cnt++;
            if (data_en) begin
                check(rx_data == expected_bit(cyc - 3), data_req,
                      int'(rx_data), int'(expected_bit(cyc - 3)));
                check(!prev_strobe, "R3 strobe width", 2, 1);
            end
            if (gap_en) begin
                if (last_strobe >= 0)
                    check(cyc - last_strobe == exp_gap, "R2 strobe spacing",
                          cyc - last_strobe, exp_gap);
                last_strobe = cyc;
            end
        end
        if (!gap_en) last_strobe = -1;
        if (mon_en && !locked) saw_unlock = 1;
        if (mon_en && fast_track) saw_fast = 1;
        prev_strobe = bit_strobe;
    end

    task automatic send(input bit b, input int len);
        if (nb < 4096) begin
            bval[nb]   = b;
            bstart[nb] = cyc;
            nb++;
        end
        din = b;
        repeat (len) @(negedge clk);
    endtask

    task automatic preamble(input int n, input int p);
        for (int i = 0; i < n; i++) send(i % 2 == 0, p);
    endtask

    task automatic random_bits(input int n, input int p, input int jit);
        for (int i = 0; i < n; i++)
            send(1'($urandom_range(0, 1)), p - jit + int'($urandom_range(0, 2 * jit)));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int sc;
        void'($urandom(32'h5EED_0C2A));
        repeat (3) @(negedge clk);
        check(!locked && !bit_strobe && !rx_data, "R1 reset state",
              int'({locked, bit_strobe, rx_data}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Automatic mode, half-bit initial offset
        enable = 1'b1;
        send(0, 12);
        preamble(2, 29);
        check(fast_track && !locked, "R9 fast before lock", int'({fast_track, locked}), 2);
        preamble(8, 29);
        check(locked, "R6 lock on fast preamble", int'(locked), 1);
        check(!fast_track, "R9 slow after lock", int'(fast_track), 0);
        fast_sel = 1'b1;
        @(negedge clk);
        check(!fast_track, "R9 fast_sel ignored", int'(fast_track), 0);
        fast_sel = 1'b0;
        preamble(14, 29);

        // Clean random data: exact spacing and correct bits
        gap_en = 1; exp_gap = period(0, 0); data_req = "R3 recovered data"; data_en = 1;
        random_bits(150, 29, 0);
        gap_en = 0;
        data_req = "R12 jitter data";
        random_bits(100, 29, 1);
        data_en = 0;
        check(locked, "R12 lock kept under jitter", int'(locked), 1);

        // Half-bit slip while locked in automatic mode
        preamble(4, 29);
        send(bval[nb - 1] ? 1'b0 : 1'b1, 29 + 14);
        mon_en = 1;
        preamble(10, 29);
        mon_en = 0;
        check(saw_unlock, "R8 unlock after misses", int'(saw_unlock), 1);
        check(saw_fast, "R10 fast after lock loss", int'(saw_fast), 1);
        preamble(16, 29);
        check(locked, "R10 relock", int'(locked), 1);

        // Leaving automatic mode
        fast_sel = 1'b1; auto_mode = 1'b0;
        @(negedge clk);
        check(fast_track, "R10 leave auto to fast", int'(fast_track), 1);
        fast_sel = 1'b0;
        @(negedge clk);
        check(!fast_track, "R11 manual slow select", int'(fast_track), 0);

        // Disable
        enable = 1'b0;
        repeat (2) @(negedge clk);
        check(!locked, "R1 disable clears lock", int'(locked), 0);
        sc = strobe_cnt;
        send(0, 100);
        check(strobe_cnt == sc, "R1 no strobes while disabled", strobe_cnt - sc, 0);

        // Manual fast lock time
        fast_sel = 1'b1;
        enable = 1'b1;
        send(0, 12);
        check(fast_track, "R11 manual fast select", int'(fast_track), 1);
        preamble(10, 29);
        check(locked, "R4 fast locks within 10 bits", int'(locked), 1);

        // Manual slow lock time
        enable = 1'b0;
        send(0, 40);
        fast_sel = 1'b0;
        enable = 1'b1;
        send(0, 12);
        preamble(8, 29);
        check(!locked, "R5 slow not locked after 8 bits", int'(locked), 0);
        preamble(16, 29);
        check(locked, "R7 slow locks within 24 bits", int'(locked), 1);

        // Divided tick: rate_div=2 with the x8 prescale
        enable = 1'b0;
        rate_div = 7'd2; rate_x8 = 1'b1; auto_mode = 1'b1;
        send(0, 40);
        enable = 1'b1;
        send(0, 100);
        preamble(26, period(2, 1));
        check(locked, "R6 lock with divided tick", int'(locked), 1);
        gap_en = 1; exp_gap = period(2, 1); data_req = "R3 divided data"; data_en = 1;
        random_bits(8, period(2, 1), 0);
        gap_en = 0; data_en = 0;

        finish_run();
    end
endmodule